// File: doc/BRIEF.md
# Transactional Cache Conflict Tracker

A small direct-mapped data cache that holds the speculative state of one hardware transaction for a single core. Every line keeps a transactional-read bit and a transactional-write bit beside its valid flag, tag and data. The local port issues begin, load, store, commit and abort operations. A snoop port carries read and write requests from other agents. Each snoop is compared against the bits of the line it indexes. A clash discards every speculative store and reports an abort with a cause code.

Stores made inside a transaction stay invisible to snoops until commit. Commit clears all tracking bits in one cycle and marks the written lines dirty. Abort clears the bits and invalidates every line that was written speculatively, so the transaction leaves either all of its stores or none. Tracking is per line, so two words that share a line can clash even when the accesses never overlap.

The cache has no backing store. A miss allocates the line filled with zeros, and dirty lines are replaced without write-back. A snoop write never carries data: a snoop write that does not conflict and hits a line invalidates it.

Top module: `tmc_tracker`

## Requirements
- R1: After reset no transaction is open, no pulse output is high and every line is invalid, so a snoop read misses.
- R2: op_i encodings: 0 idle, 1 begin, 2 load, 3 store, 4 commit, 5 abort. Begin opens a transaction only when none is open, which raises in_tx_o. Commit and abort issued outside a transaction do nothing.
- R3: Address layout is {tag, index, word}, with the word select in the least significant bits. A load gives rvalid_o and rdata_o one cycle later. A store followed by a load returns the stored word. A miss allocates a zero-filled line. A store outside a transaction marks its line dirty at once.
- R4: A snoop read of a line whose write bit is set returns snp_hit_o=0, so it sees no speculative data, and it aborts the transaction.
- R5: abort_cause_o encodings: 1 conflict, 2 capacity, 3 explicit, 0 when abort_o is low. A snoop write that hits a line with the read bit or the write bit set aborts with cause 1.
- R6: A snoop read of a line that has only its read bit set is serviced (snp_hit_o=1 with the data and the dirty flag) and does not abort.
- R7: A snoop that hits a line with neither bit set never aborts. A snoop write that hits such a line invalidates it.
- R8: Commit gives a one-cycle commit_o and closes the transaction. Afterwards the written data is visible to snoop reads with the dirty flag set, and the tracking bits are clear.
- R9: After an abort, lines that were written speculatively are invalid and lines that were only read stay valid.
- R10: A snoop write to another word of a tracked line still aborts with cause 1.
- R11: A load or store inside a transaction whose line slot holds a different tag with a tracking bit set aborts with cause 2, and the access is not performed.
- R12: An abort operation inside a transaction aborts with cause 3. abort_o is high for one cycle only.
- R13: When a conflicting snoop and a commit fall in the same cycle, the abort wins and commit_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Local operation code |
| addr_i | input | ADDR_W | Local word address |
| wdata_i | input | DATA_W | Local store data |
| rdata_o | output | DATA_W | Load data |
| rvalid_o | output | 1 | Load data valid |
| in_tx_o | output | 1 | Transaction open |
| commit_o | output | 1 | Commit pulse |
| abort_o | output | 1 | Abort pulse |
| abort_cause_o | output | 2 | Abort cause code |
| snp_req_i | input | 1 | Snoop request valid |
| snp_we_i | input | 1 | Snoop is a write |
| snp_addr_i | input | ADDR_W | Snoop word address |
| snp_resp_o | output | 1 | Snoop response valid |
| snp_hit_o | output | 1 | Snoop serviced on a valid line |
| snp_rdata_o | output | DATA_W | Snoop read data |
| snp_dirty_o | output | 1 | Serviced line is dirty |

## Verification
The assertions assume that a snoop write never targets the line that a local load or store addresses in the same cycle. The RTL resolves that collision in favour of the snoop, but no property covers it. The random phase issues a snoop only in cycles whose local operation is not a load or a store, so this case never arises there. The op code is assumed to be one of the six defined values, and the stimulus draws only from that set. Directed sequences place conflicting snoops on purpose: on written lines, on read lines, on a neighbouring word, and in the same cycle as a commit.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [2:0] {
    OP_NOP    = 3'd0,
    OP_BEGIN  = 3'd1,
    OP_LOAD   = 3'd2,
    OP_STORE  = 3'd3,
    OP_COMMIT = 3'd4,
    OP_ABORT  = 3'd5
  } op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'd0,
    CAUSE_CONFLICT = 2'd1,
    CAUSE_CAPACITY = 2'd2,
    CAUSE_EXPLICIT = 2'd3
  } cause_e;
endpackage

// File: rtl/tmc_snoop_check.sv
module tmc_snoop_check #(
  parameter int TAG_W = 3
) (
  input  logic             req_i,
  input  logic             we_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic             line_valid_i,
  input  logic [TAG_W-1:0] line_tag_i,
  input  logic             line_r_i,
  input  logic             line_w_i,
  output logic             hit_o,
  output logic             conflict_o
);
  always_comb begin
    hit_o      = req_i && line_valid_i && (line_tag_i == tag_i);
    // write clashes with any tracking bit, read only with a pending write
    conflict_o = hit_o && (line_w_i || (we_i && line_r_i));
  end
endmodule

// File: rtl/tmc_ctrl.sv
module tmc_ctrl
  import tmc_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [2:0] op_i,
  input  logic       conflict_i,
  input  logic       victim_busy_i,
  output logic       in_tx_o,
  output logic       acc_now_o,
  output logic       abort_now_o,
  output logic       commit_now_o,
  output logic       abort_o,
  output logic [1:0] abort_cause_o,
  output logic       commit_o
);
  logic   in_tx_q, is_acc, cap, expl, begin_now;
  cause_e cause;

  always_comb begin
    is_acc       = (op_i == OP_LOAD) || (op_i == OP_STORE);
    cap          = in_tx_q && is_acc && victim_busy_i;
    expl         = in_tx_q && (op_i == OP_ABORT);
    abort_now_o  = conflict_i || cap || expl;
    cause        = conflict_i ? CAUSE_CONFLICT :
                   cap        ? CAUSE_CAPACITY :
                   expl       ? CAUSE_EXPLICIT : CAUSE_NONE;
    commit_now_o = in_tx_q && (op_i == OP_COMMIT) && !abort_now_o;
    begin_now    = !in_tx_q && (op_i == OP_BEGIN);
    acc_now_o    = is_acc && !abort_now_o;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_tx_q       <= 1'b0;
      abort_o       <= 1'b0;
      abort_cause_o <= CAUSE_NONE;
      commit_o      <= 1'b0;
    end else begin
      if (begin_now) in_tx_q <= 1'b1;
      else if (abort_now_o || commit_now_o) in_tx_q <= 1'b0;
      abort_o       <= abort_now_o;
      abort_cause_o <= cause;
      commit_o      <= commit_now_o;
    end
  end

  assign in_tx_o = in_tx_q;

  a_r12_abort_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |=> !abort_o);
  a_r2_abort_closes_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o |-> !in_tx_o);
  a_r13_abort_commit_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(abort_o && commit_o));
  a_r5_cause_iff_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_o == (abort_cause_o != CAUSE_NONE));
endmodule

// File: rtl/tmc_line.sv
module tmc_line #(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16,
  parameter int WPL    = 2,
  localparam int OFF_W = (WPL > 1) ? $clog2(WPL) : 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  sel_i,
  input  logic                  fill_i,
  input  logic                  wr_i,
  input  logic [OFF_W-1:0]      word_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [TAG_W-1:0]      tag_i,
  input  logic                  set_r_i,
  input  logic                  set_w_i,
  input  logic                  mark_dirty_i,
  input  logic                  commit_i,
  input  logic                  abort_i,
  input  logic                  snp_inval_i,
  output logic                  valid_o,
  output logic                  dirty_o,
  output logic                  rbit_o,
  output logic                  wbit_o,
  output logic [TAG_W-1:0]      tag_o,
  output logic [WPL*DATA_W-1:0] data_o
);
  logic                  valid_q, dirty_q, r_q, w_q;
  logic [TAG_W-1:0]      tag_q;
  logic [WPL*DATA_W-1:0] data_q, data_n;

  always_comb begin
    data_n = fill_i ? '0 : data_q;
    if (wr_i) data_n[int'(word_i)*DATA_W +: DATA_W] = wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      dirty_q <= 1'b0;
      r_q     <= 1'b0;
      w_q     <= 1'b0;
      tag_q   <= '0;
      data_q  <= '0;
    end else begin
      if (abort_i) begin
        r_q <= 1'b0;
        w_q <= 1'b0;
        if (w_q) valid_q <= 1'b0;
      end else if (commit_i) begin
        r_q <= 1'b0;
        w_q <= 1'b0;
        if (w_q) dirty_q <= 1'b1;
      end else if (sel_i && !snp_inval_i) begin
        data_q <= data_n;
        if (fill_i) begin
          valid_q <= 1'b1;
          tag_q   <= tag_i;
          r_q     <= set_r_i;
          w_q     <= set_w_i;
          dirty_q <= mark_dirty_i;
        end else begin
          r_q <= r_q | set_r_i;
          w_q <= w_q | set_w_i;
          if (mark_dirty_i) dirty_q <= 1'b1;
        end
      end
      if (snp_inval_i) begin
        valid_q <= 1'b0;
        dirty_q <= 1'b0;
      end
    end
  end

  assign valid_o = valid_q;
  assign dirty_o = dirty_q;
  assign rbit_o  = r_q;
  assign wbit_o  = w_q;
  assign tag_o   = tag_q;
  assign data_o  = data_q;

  a_r9_abort_drops_written: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (abort_i && w_q) |=> !valid_q);
  a_r8_commit_clears_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (!r_q && !w_q));
  a_r8_commit_marks_dirty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && w_q && !snp_inval_i) |=> dirty_q);
endmodule

// File: rtl/tmc_tracker.sv
module tmc_tracker
  import tmc_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int LINES  = 4,
  parameter int WPL    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  output logic              in_tx_o,
  output logic              commit_o,
  output logic              abort_o,
  output logic [1:0]        abort_cause_o,
  input  logic              snp_req_i,
  input  logic              snp_we_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  output logic              snp_resp_o,
  output logic              snp_hit_o,
  output logic [DATA_W-1:0] snp_rdata_o,
  output logic              snp_dirty_o
);
  localparam int IDX_W = $clog2(LINES);
  localparam int OFF_W = $clog2(WPL);
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W;

  logic [LINES-1:0]      valid_v, dirty_v, rbit_v, wbit_v;
  logic [TAG_W-1:0]      tag_a  [LINES];
  logic [WPL*DATA_W-1:0] data_a [LINES];

  logic [IDX_W-1:0] l_idx, s_idx;
  logic [OFF_W-1:0] l_off, s_off;
  logic [TAG_W-1:0] l_tag, s_tag;
  logic             l_hit, victim_busy, is_ld, is_st;
  logic             s_hit, s_conf, s_ok;
  logic             acc_now, abort_now, commit_now;
  logic [DATA_W-1:0] l_word, s_word;

  always_comb begin
    l_idx  = addr_i[OFF_W +: IDX_W];
    l_off  = addr_i[OFF_W-1:0];
    l_tag  = addr_i[ADDR_W-1 -: TAG_W];
    s_idx  = snp_addr_i[OFF_W +: IDX_W];
    s_off  = snp_addr_i[OFF_W-1:0];
    s_tag  = snp_addr_i[ADDR_W-1 -: TAG_W];
    is_ld  = (op_i == OP_LOAD);
    is_st  = (op_i == OP_STORE);
    l_hit  = valid_v[l_idx] && (tag_a[l_idx] == l_tag);
    // another tag would have to evict a tracked line
    victim_busy = !l_hit && (rbit_v[l_idx] || wbit_v[l_idx]);
    l_word = l_hit ? data_a[l_idx][int'(l_off)*DATA_W +: DATA_W] : '0;
    s_word = data_a[s_idx][int'(s_off)*DATA_W +: DATA_W];
    s_ok   = s_hit && !s_conf;
  end

  tmc_snoop_check #(.TAG_W(TAG_W)) u_snoop (
    .req_i       (snp_req_i),
    .we_i        (snp_we_i),
    .tag_i       (s_tag),
    .line_valid_i(valid_v[s_idx]),
    .line_tag_i  (tag_a[s_idx]),
    .line_r_i    (rbit_v[s_idx]),
    .line_w_i    (wbit_v[s_idx]),
    .hit_o       (s_hit),
    .conflict_o  (s_conf)
  );

  tmc_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .op_i         (op_i),
    .conflict_i   (s_conf),
    .victim_busy_i(victim_busy),
    .in_tx_o      (in_tx_o),
    .acc_now_o    (acc_now),
    .abort_now_o  (abort_now),
    .commit_now_o (commit_now),
    .abort_o      (abort_o),
    .abort_cause_o(abort_cause_o),
    .commit_o     (commit_o)
  );

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel, inval;
    assign sel   = acc_now && (l_idx == IDX_W'(i));
    assign inval = s_ok && snp_we_i && (s_idx == IDX_W'(i));
    tmc_line #(.TAG_W(TAG_W), .DATA_W(DATA_W), .WPL(WPL)) u_line (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sel_i       (sel),
      .fill_i      (!l_hit),
      .wr_i        (is_st),
      .word_i      (l_off),
      .wdata_i     (wdata_i),
      .tag_i       (l_tag),
      .set_r_i     (in_tx_o && is_ld),
      .set_w_i     (in_tx_o && is_st),
      .mark_dirty_i(!in_tx_o && is_st),
      .commit_i    (commit_now),
      .abort_i     (abort_now),
      .snp_inval_i (inval),
      .valid_o     (valid_v[i]),
      .dirty_o     (dirty_v[i]),
      .rbit_o      (rbit_v[i]),
      .wbit_o      (wbit_v[i]),
      .tag_o       (tag_a[i]),
      .data_o      (data_a[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_o    <= 1'b0;
      rdata_o     <= '0;
      snp_resp_o  <= 1'b0;
      snp_hit_o   <= 1'b0;
      snp_rdata_o <= '0;
      snp_dirty_o <= 1'b0;
    end else begin
      rvalid_o    <= acc_now && is_ld;
      rdata_o     <= (acc_now && is_ld) ? l_word : '0;
      snp_resp_o  <= snp_req_i;
      snp_hit_o   <= s_ok;
      snp_rdata_o <= (s_ok && !snp_we_i) ? s_word : '0;
      snp_dirty_o <= s_ok && dirty_v[s_idx];
    end
  end

  a_r2_bits_only_in_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(rbit_v | wbit_v)) |-> in_tx_o);
  a_r4_no_spec_leak: assert property (@(posedge clk_i) disable iff (!rst_ni)
    snp_hit_o |-> !(abort_o && abort_cause_o == CAUSE_CONFLICT));
  a_r11_no_access_on_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !abort_o);
endmodule

// File: tb/tb_tmc_tracker.sv
module tb_tmc_tracker;
  localparam int AW = 6, DW = 16, NL = 4, NW = 2;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [2:0]    op = '0;
  logic [AW-1:0] addr = '0, saddr = '0;
  logic [DW-1:0] wdata = '0;
  logic          sreq = 1'b0, swe = 1'b0;
  logic [DW-1:0] rdata, srdata;
  logic          rvalid, in_tx, commit, abort_p, sresp, shit, sdirty;
  logic [1:0]    cause;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  tmc_tracker #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL), .WPL(NW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rvalid_o(rvalid), .in_tx_o(in_tx), .commit_o(commit),
    .abort_o(abort_p), .abort_cause_o(cause), .snp_req_i(sreq), .snp_we_i(swe),
    .snp_addr_i(saddr), .snp_resp_o(sresp), .snp_hit_o(shit),
    .snp_rdata_o(srdata), .snp_dirty_o(sdirty)
  );

  // reference state from the requirements
  bit          m_valid [NL], m_dirty [NL], m_r [NL], m_w [NL], m_tx;
  int          m_tag   [NL];
  logic [DW-1:0] m_data [NL][NW];
  bit          e_abort, e_commit, e_rvalid, e_shit, e_sdirty;
  logic [1:0]  e_cause;
  logic [DW-1:0] e_rdata, e_srdata;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] A(input int t, input int i, input int o);
    return AW'((t << 3) | (i << 1) | o);
  endfunction

  task automatic model_step();
    int li, lo, lt, si, so, st;
    bit lhit, busy, sh, conf, acc, cap, expl, ab, cm, bg, accn, ok;
    li = int'(addr[2:1]); lo = int'(addr[0]); lt = int'(addr[5:3]);
    si = int'(saddr[2:1]); so = int'(saddr[0]); st = int'(saddr[5:3]);
    lhit = m_valid[li] && m_tag[li] == lt;
    busy = !lhit && (m_r[li] || m_w[li]);
    sh   = sreq && m_valid[si] && m_tag[si] == st;
    conf = sh && (m_w[si] || (swe && m_r[si]));
    acc  = (op == 3'd2) || (op == 3'd3);
    cap  = m_tx && acc && busy;
    expl = m_tx && op == 3'd5;
    ab   = conf || cap || expl;
    cm   = m_tx && op == 3'd4 && !ab;
    bg   = !m_tx && op == 3'd1;
    accn = acc && !ab;
    ok   = sh && !conf;
    e_abort  = ab;
    e_cause  = conf ? 2'd1 : cap ? 2'd2 : expl ? 2'd3 : 2'd0;
    e_commit = cm;
    e_rvalid = accn && op == 3'd2;
    e_rdata  = (e_rvalid && lhit) ? m_data[li][lo] : '0;
    e_shit   = ok;
    e_srdata = (ok && !swe) ? m_data[si][so] : '0;
    e_sdirty = ok && m_dirty[si];
    for (int j = 0; j < NL; j++) begin
      if (ab) begin
        if (m_w[j]) m_valid[j] = 1'b0;
        m_r[j] = 1'b0; m_w[j] = 1'b0;
      end else if (cm) begin
        if (m_w[j]) m_dirty[j] = 1'b1;
        m_r[j] = 1'b0; m_w[j] = 1'b0;
      end
    end
    if (accn && !(ok && swe && si == li)) begin
      if (!lhit) begin
        m_valid[li] = 1'b1; m_tag[li] = lt; m_dirty[li] = 1'b0;
        m_r[li] = 1'b0; m_w[li] = 1'b0;
        for (int k = 0; k < NW; k++) m_data[li][k] = '0;
      end
      if (op == 3'd3) begin
        m_data[li][lo] = wdata;
        if (m_tx) m_w[li] = 1'b1; else m_dirty[li] = 1'b1;
      end else if (m_tx) m_r[li] = 1'b1;
    end
    if (ok && swe) begin m_valid[si] = 1'b0; m_dirty[si] = 1'b0; end
    if (bg) m_tx = 1'b1;
    else if (ab || cm) m_tx = 1'b0;
  endtask

  // drive one cycle at the falling edge, compare after the rising edge
  task automatic cyc(input string req, input logic [2:0] o, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input bit sr, input bit sw,
                     input logic [AW-1:0] sa);
    @(negedge clk);
    op = o; addr = a; wdata = d; sreq = sr; swe = sw; saddr = sa;
    model_step();
    @(posedge clk); #1;
    chk(abort_p == e_abort, {req, " abort"}, abort_p, e_abort);
    chk(cause == e_cause, {req, " cause"}, cause, e_cause);
    chk(commit == e_commit, {req, " commit"}, commit, e_commit);
    chk(in_tx == m_tx, {req, " in_tx"}, in_tx, m_tx);
    chk(rvalid == e_rvalid, {req, " rvalid"}, rvalid, e_rvalid);
    if (e_rvalid) chk(rdata == e_rdata, {req, " rdata"}, rdata, e_rdata);
    chk(sresp == sr, {req, " snp_resp"}, sresp, sr);
    chk(shit == e_shit, {req, " snp_hit"}, shit, e_shit);
    chk(srdata == e_srdata, {req, " snp_rdata"}, srdata, e_srdata);
    chk(sdirty == e_sdirty, {req, " snp_dirty"}, sdirty, e_sdirty);
    op = '0; sreq = 1'b0; swe = 1'b0;
  endtask

  task automatic opc(input string req, input logic [2:0] o, input logic [AW-1:0] a,
                     input logic [DW-1:0] d);
    cyc(req, o, a, d, 1'b0, 1'b0, '0);
  endtask

  task automatic snp(input string req, input bit sw, input logic [AW-1:0] sa);
    cyc(req, 3'd0, '0, '0, 1'b1, sw, sa);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int j = 0; j < NL; j++) begin
      m_valid[j] = 0; m_dirty[j] = 0; m_r[j] = 0; m_w[j] = 0; m_tag[j] = 0;
      for (int k = 0; k < NW; k++) m_data[j][k] = '0;
    end
    m_tx = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(in_tx == 0 && abort_p == 0 && commit == 0 && rvalid == 0, "R1 pulses", in_tx, 0);
    @(negedge clk) rst_n = 1'b1;
    snp("R1", 1'b0, A(0, 0, 0));
    chk(shit == 0, "R1 snoop miss", shit, 0);

    // R3 plain store/load, zero fill
    opc("R3", 3'd3, A(1, 0, 0), 16'h1111);
    opc("R3", 3'd2, A(1, 0, 0), '0);
    chk(rvalid && rdata == 16'h1111, "R3 load back", rdata, 16'h1111);
    opc("R3", 3'd2, A(1, 0, 1), '0);
    chk(rdata == 16'h0, "R3 zero fill word", rdata, 0);

    // R2 commit/abort outside tx, begin twice
    opc("R2", 3'd4, '0, '0);
    chk(commit == 0, "R2 commit idle", commit, 0);
    opc("R2", 3'd5, '0, '0);
    chk(abort_p == 0, "R2 abort idle", abort_p, 0);
    opc("R2", 3'd1, '0, '0);
    chk(in_tx == 1, "R2 begin", in_tx, 1);
    opc("R2", 3'd1, '0, '0);
    chk(in_tx == 1 && abort_p == 0, "R2 nested begin", in_tx, 1);

    // R4 speculative store hidden, R9 dropped
    opc("R4", 3'd3, A(2, 1, 0), 16'hAAAA);
    snp("R4", 1'b0, A(2, 1, 0));
    chk(shit == 0 && abort_p && cause == 2'd1, "R4 read of written line", {shit, cause}, 1);
    snp("R9", 1'b0, A(2, 1, 0));
    chk(shit == 0, "R9 written line dropped", shit, 0);

    // R6 read-only line serviced; R10 false conflict; R9 read line kept
    opc("R6", 3'd1, '0, '0);
    opc("R6", 3'd2, A(1, 0, 0), '0);
    snp("R6", 1'b0, A(1, 0, 0));
    chk(shit && srdata == 16'h1111 && sdirty && !abort_p, "R6 shared read", srdata, 16'h1111);
    snp("R10", 1'b1, A(1, 0, 1));
    chk(abort_p && cause == 2'd1, "R10 false conflict", cause, 1);
    snp("R9", 1'b0, A(1, 0, 0));
    chk(shit && srdata == 16'h1111, "R9 read line kept", srdata, 16'h1111);

    // R8 commit publishes, R7 untracked snoop write invalidates
    opc("R8", 3'd1, '0, '0);
    opc("R8", 3'd3, A(3, 2, 1), 16'hBEEF);
    opc("R8", 3'd4, '0, '0);
    chk(commit && !in_tx, "R8 commit pulse", commit, 1);
    snp("R8", 1'b0, A(3, 2, 1));
    chk(shit && srdata == 16'hBEEF && sdirty, "R8 published", srdata, 16'hBEEF);
    opc("R7", 3'd1, '0, '0);
    opc("R7", 3'd2, A(1, 0, 0), '0);
    snp("R7", 1'b1, A(3, 2, 1));
    chk(!abort_p && shit && in_tx, "R7 untracked write", abort_p, 0);
    snp("R7", 1'b0, A(3, 2, 1));
    chk(shit == 0, "R7 invalidated", shit, 1);
    opc("R7", 3'd4, '0, '0);

    // R11 capacity
    opc("R11", 3'd1, '0, '0);
    opc("R11", 3'd2, A(1, 3, 0), '0);
    opc("R11", 3'd3, A(2, 3, 0), 16'h7777);
    chk(abort_p && cause == 2'd2 && !rvalid, "R11 capacity", cause, 2);
    snp("R11", 1'b0, A(2, 3, 0));
    chk(shit == 0, "R11 store not done", shit, 0);

    // R12 explicit abort, one cycle
    opc("R12", 3'd1, '0, '0);
    opc("R12", 3'd5, '0, '0);
    chk(abort_p && cause == 2'd3, "R12 explicit", cause, 3);
    opc("R12", 3'd0, '0, '0);
    chk(abort_p == 0, "R12 pulse width", abort_p, 0);

    // R13 conflict beats commit
    opc("R13", 3'd1, '0, '0);
    opc("R13", 3'd3, A(0, 1, 0), 16'h0005);
    cyc("R13", 3'd4, '0, '0, 1'b1, 1'b1, A(0, 1, 1));
    chk(abort_p && !commit && cause == 2'd1, "R13 abort wins", commit, 0);

    // random mix against the reference
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] o;
      int w;
      bit sr;
      w = int'($urandom_range(0, 99));
      o = (w < 10) ? 3'd1 : (w < 40) ? 3'd2 : (w < 70) ? 3'd3 :
          (w < 80) ? 3'd4 : (w < 84) ? 3'd5 : 3'd0;
      sr = (o != 3'd2 && o != 3'd3) && ($urandom_range(0, 2) != 0);
      cyc("R3 R5 random", o, AW'($urandom), DW'($urandom), sr, 1'($urandom), AW'($urandom));
    end

    summary();
  end
endmodule